// File: doc/BRIEF.md
# Leveled Priority Interrupt Controller

This block gathers the interrupt request lines of a subsystem and tells the processor which one to service next. There are fifty-six internal request lines, whose urgency software sets, and seven external lines, whose urgency is fixed. Every internal source carries a 3-bit level and a priority that ranks it among the sources sharing that level. Every source, internal or external, has its own mask bit. The highest eligible request goes to the processor as a level code together with a vector number. Each source has its own vector number.

The processor drives its current mask level into the block. A request goes through only when its level is above that mask, except at level 7, which always goes through. To take an interrupt, the processor raises an acknowledge line. The block then captures the vector of the request that is winning at that moment and holds it steady until the acknowledge line drops. The peripherals themselves clear their request flags. The block never clears them.

Top module: `prio_intc`

## Requirements
- R1: After reset every source is masked, every internal level is 0, `req_level` reads 0, `req_vector` reads the spurious code 24 and `ack_valid` is low.
- R2: A configuration write to an internal index (0..55) sets that source's level, priority and mask bit. A write to an external index (56..62) changes only the mask bit; the level and priority fields are ignored.
- R3: Among eligible requests, the one with the highest level wins.
- R4: Among eligible requests of equal level, the one with the larger priority value wins.
- R5: When level and priority are both equal, the lower source index wins.
- R6: A request is eligible only if its level is strictly greater than `cpu_mask_lvl`, or its level is 7. Level 0 is never eligible.
- R7: A source whose mask bit is 1 takes no part in arbitration.
- R8: One clock after its inputs are applied, the block shows the winner on `req_level` (its level) and `req_vector` (64 plus the source index). When no request is eligible, `req_level` is 0 and `req_vector` is 24.
- R9: External source k (index 56+k, k = 0..6) has fixed level k+1 and fixed priority 15.
- R10: On the clock edge where `iack` is first seen high, `ack_vector` captures the current winner's vector, or 24 if there is no winner. From the next cycle `ack_valid` is high. `ack_vector` holds its value while `iack` stays high, and `ack_valid` goes low one clock after `iack` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_int | input | 56 | Internal request lines, index 0..55 |
| irq_ext | input | 7 | External request lines, source index 56+k |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 6 | Source index for the write |
| cfg_level | input | 3 | Level to program (internal only) |
| cfg_prio | input | 4 | Priority to program (internal only) |
| cfg_mask | input | 1 | Mask bit to program, 1 = masked |
| cpu_mask_lvl | input | 3 | Processor's current mask level |
| iack | input | 1 | Acknowledge request from the processor |
| req_level | output | 3 | Level of the pending winner, 0 if none |
| req_vector | output | 8 | Vector of the pending winner |
| ack_valid | output | 1 | Captured vector is valid |
| ack_vector | output | 8 | Vector captured at acknowledge |

## Verification
On every cycle, the assertions check the following. A presented level must beat the mask level from the previous cycle, unless it is 7. A presented vector must fall inside the range of valid source numbers. An external vector must be paired with its fixed level. The captured vector must not move while the acknowledge is held, and `ack_valid` is never seen without a preceding `iack`. The order of arbitration, which covers level first, then priority, then index, can only be shown by the bench's scenarios, because that needs knowledge of the programmed configuration. The same is true of the effect of mask bits, the handling of external writes and the spurious vector.

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int N_INT    = 56,
  parameter int N_EXT    = 7,
  parameter int PRIO_W   = 4,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64,
  parameter int SPUR_VEC = 24,
  parameter int IDX_W    = $clog2(N_INT + N_EXT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_INT-1:0]   irq_int,
  input  logic [N_EXT-1:0]   irq_ext,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [2:0]         cfg_level,
  input  logic [PRIO_W-1:0]  cfg_prio,
  input  logic               cfg_mask,
  input  logic [2:0]         cpu_mask_lvl,
  input  logic               iack,
  output logic [2:0]         req_level,
  output logic [VEC_W-1:0]   req_vector,
  output logic               ack_valid,
  output logic [VEC_W-1:0]   ack_vector
);
  localparam int N_SRC = N_INT + N_EXT;
  localparam int KEY_W = 3 + PRIO_W;

  logic [2:0]        lvl_q  [N_INT];
  logic [PRIO_W-1:0] prio_q [N_INT];
  logic [N_SRC-1:0]  mask_q;
  logic [2:0]        src_lvl  [N_SRC];
  logic [PRIO_W-1:0] src_prio [N_SRC];
  logic [N_SRC-1:0]  irq_all;
  logic              iack_q;

  assign irq_all = {irq_ext, irq_int};

  for (genvar i = 0; i < N_INT; i++) begin : g_int
    assign src_lvl[i]  = lvl_q[i];
    assign src_prio[i] = prio_q[i];
  end
  for (genvar k = 0; k < N_EXT; k++) begin : g_ext
    assign src_lvl[N_INT+k]  = 3'(k + 1);
    assign src_prio[N_INT+k] = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      for (int i = 0; i < N_INT; i++) begin
        lvl_q[i]  <= '0;
        prio_q[i] <= '0;
      end
    end else if (cfg_we) begin
      for (int i = 0; i < N_SRC; i++)
        if (cfg_idx == IDX_W'(i)) mask_q[i] <= cfg_mask;
      for (int i = 0; i < N_INT; i++)
        if (cfg_idx == IDX_W'(i)) begin
          lvl_q[i]  <= cfg_level;
          prio_q[i] <= cfg_prio;
        end
    end
  end

  logic             found;
  logic [KEY_W-1:0] best_key, key_c;
  logic [IDX_W-1:0] best_idx;
  logic [VEC_W-1:0] win_vec;

  always_comb begin
    found    = 1'b0;
    best_key = '0;
    best_idx = '0;
    key_c    = '0;
    for (int i = 0; i < N_SRC; i++) begin
      key_c = {src_lvl[i], src_prio[i]};
      if (irq_all[i] && !mask_q[i] && src_lvl[i] != 3'd0 &&
          (src_lvl[i] > cpu_mask_lvl || src_lvl[i] == 3'd7) &&
          (!found || key_c > best_key)) begin
        found    = 1'b1;
        best_key = key_c;
        best_idx = IDX_W'(i);
      end
    end
  end

  assign win_vec = found ? VEC_W'(VEC_BASE) + VEC_W'(best_idx) : VEC_W'(SPUR_VEC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_level  <= '0;
      req_vector <= VEC_W'(SPUR_VEC);
      iack_q     <= 1'b0;
      ack_valid  <= 1'b0;
      ack_vector <= VEC_W'(SPUR_VEC);
    end else begin
      req_level  <= found ? best_key[KEY_W-1 -: 3] : 3'd0;
      req_vector <= win_vec;
      iack_q     <= iack;
      ack_valid  <= iack;
      if (iack && !iack_q) ack_vector <= win_vec;
    end
  end
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
  parameter int N_INT    = 56,
  parameter int N_EXT    = 7,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       cpu_mask_lvl,
  input logic             iack,
  input logic [2:0]       req_level,
  input logic [VEC_W-1:0] req_vector,
  input logic             ack_valid,
  input logic [VEC_W-1:0] ack_vector
);
  a_r6_level_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (req_level != 3'd0) |-> (req_level == 3'd7 || req_level > $past(cpu_mask_lvl)));

  a_r8_vector_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (req_level != 3'd0) |-> (req_vector >= VEC_W'(VEC_BASE) &&
                             req_vector < VEC_W'(VEC_BASE + N_INT + N_EXT)));

  a_r9_ext_fixed_level: assert property (@(posedge clk) disable iff (!rst_n)
    (req_level != 3'd0 && req_vector >= VEC_W'(VEC_BASE + N_INT)) |->
    (req_level == 3'(req_vector - VEC_W'(VEC_BASE + N_INT) + VEC_W'(1))));

  a_r10_vector_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && iack) |=> $stable(ack_vector));

  a_r10_valid_needs_iack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(iack));
endmodule

bind prio_intc prio_intc_chk #(
  .N_INT(N_INT), .N_EXT(N_EXT), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_mask_lvl(cpu_mask_lvl), .iack(iack),
  .req_level(req_level), .req_vector(req_vector),
  .ack_valid(ack_valid), .ack_vector(ack_vector)
);

// File: tb/prio_intc_bench.sv
module prio_intc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [55:0] irq_int = '0;
  logic [6:0]  irq_ext = '0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_idx = '0;
  logic [2:0]  cfg_level = '0;
  logic [3:0]  cfg_prio = '0;
  logic        cfg_mask = 1'b0;
  logic [2:0]  cpu_mask_lvl = '0;
  logic        iack = 1'b0;
  logic [2:0]  req_level;
  logic [7:0]  req_vector;
  logic        ack_valid;
  logic [7:0]  ack_vector;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prio_intc u_prio_intc (.*);

  task automatic step(); @(posedge clk); @(negedge clk); endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; irq_int = '0; irq_ext = '0; cpu_mask_lvl = '0; iack = 0; cfg_we = 0;
    step(); step();
    rst_n = 1;
    step();
  endtask

  task automatic cfg(int idx, int lvl, int prio, bit msk);
    cfg_we = 1; cfg_idx = 6'(idx); cfg_level = 3'(lvl); cfg_prio = 4'(prio); cfg_mask = msk;
    step();
    cfg_we = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 req_level", req_level, 0);
    chk("R1 req_vector", req_vector, 24);
    chk("R1 ack_valid", ack_valid, 0);
    irq_int = '1; irq_ext = '1; step();
    chk("R1 all masked after reset", req_level, 0);
  endtask

  task automatic t_order();
    do_reset();
    cfg(3, 2, 9, 0); cfg(10, 5, 0, 0); cfg(20, 5, 9, 0);
    irq_int[3] = 1; irq_int[10] = 1; step();
    chk("R3 higher level wins level", req_level, 5);
    chk("R3 higher level wins vector", req_vector, 74);
    cfg(3, 5, 9, 0); step();
    chk("R4 higher prio wins", req_vector, 67);
    chk("R2 reprogrammed level", req_level, 5);
    irq_int[20] = 1; step();
    chk("R5 tie lower index", req_vector, 67);
    irq_int[3] = 0; step();
    chk("R5 tie next index", req_vector, 84);
  endtask

  task automatic t_masklvl();
    do_reset();
    cfg(10, 5, 0, 0); cfg(30, 7, 0, 0);
    irq_int[10] = 1; cpu_mask_lvl = 5; step();
    chk("R6 level equal to mask blocked", req_level, 0);
    chk("R8 spurious vector when none", req_vector, 24);
    cpu_mask_lvl = 4; step();
    chk("R6 level above mask passes", req_vector, 74);
    irq_int[30] = 1; cpu_mask_lvl = 7; step();
    chk("R6 level 7 non-maskable level", req_level, 7);
    chk("R6 level 7 non-maskable vector", req_vector, 94);
    cfg(30, 7, 0, 1); cpu_mask_lvl = 0; step();
    chk("R7 masked source excluded", req_vector, 74);
    cfg(10, 0, 0, 0); step();
    chk("R6 level 0 never eligible", req_level, 0);
  endtask

  task automatic t_ext();
    do_reset();
    irq_ext[2] = 1; step();
    chk("R7 external masked at reset", req_level, 0);
    cfg(58, 1, 0, 0); step();
    chk("R2 R9 ext level fixed", req_level, 3);
    chk("R9 ext vector", req_vector, 122);
    cfg(5, 3, 15, 0); irq_int[5] = 1; step();
    chk("R9 ext prio 15 ties lower index", req_vector, 69);
    cfg(5, 3, 14, 0); step();
    chk("R9 ext prio 15 beats 14", req_vector, 122);
  endtask

  task automatic t_ack();
    do_reset();
    cfg(10, 4, 1, 0); cfg(12, 6, 1, 0);
    irq_int[10] = 1; step();
    iack = 1; step();
    chk("R10 ack_valid high", ack_valid, 1);
    chk("R10 captured vector", ack_vector, 74);
    irq_int[12] = 1; step(); step();
    chk("R10 req moves on", req_vector, 76);
    chk("R10 vector held", ack_vector, 74);
    chk("R10 still valid", ack_valid, 1);
    iack = 0; step();
    chk("R10 valid drops", ack_valid, 0);
    irq_int = '0; step();
    iack = 1; step();
    chk("R10 spurious capture", ack_vector, 24);
    iack = 0; step();
  endtask

  initial begin
    t_reset();
    t_order();
    t_masklvl();
    t_ext();
    t_ack();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule